// File: doc/BRIEF.md
# HDLC Maintenance Data-Link Receiver

This block takes a bit-serial maintenance data link, one bit per strobe, and recovers HDLC-style frames from it. It hunts for the flag pattern 01111110 and treats seven or more ones in a row as an abort. Inside a frame it removes stuffed zeros and assembles octets, least significant bit first. When FCS checking is enabled it verifies a CRC-16 over the frame. Payload octets are written into a 128-entry byte FIFO, which a processor drains one byte per read strobe.

Each frame leaves a set of status bits when it ends: frame ended, ended by abort, length not a whole number of octets, FIFO overwrite, and FCS mismatch. It also keeps a 7-bit count of the octets the frame wrote into the FIFO. The FIFO never refuses a byte. When it is full, a new byte replaces the oldest unread byte, and the frame that caused this reports it.

Top module: `hdlc_dl_rx`

## Requirements
- R1: After reset the FIFO is empty (`fifo_empty`=1), all five status bits are 0 and `frm_bytes` is 0.
- R2: A flag is 0 followed by six 1s and a 0. Flags with no data bits between them produce no frame: nothing is written to the FIFO and no status changes.
- R3: Inside a frame, a 0 received after five consecutive 1s is discarded before octets are assembled.
- R4: Octets are assembled with the first received bit as bit 0. They enter the FIFO in arrival order, and `rd_data` shows the oldest unread byte. A frame closed by a flag sets `frm_done`=1 and `frm_abort`=0.
- R5: Seven consecutive 1s abort the frame. This sets `frm_done`=1 and `frm_abort`=1 with `frm_nonoct`=0 and `frm_fcs_err`=0. The receiver then ignores bits until the next flag.
- R6: `frm_nonoct` is set at a flag close when the destuffed bit count between the flags is not a multiple of 8.
- R7: With `fcs_on`=1, the last two octets before the closing flag are the FCS and are not stored. The CRC is x^16+x^12+x^5+1, preset 0xFFFF, bits processed LSB first. The sender transmits the complemented CRC, low byte first. `frm_fcs_err` is set when the register over data plus FCS is not 0xF0B8.
- R8: With `fcs_on`=0, the FCS octets are stored and counted like data, and `frm_fcs_err` stays 0.
- R9: `frm_bytes` equals the number of octets the current or last frame wrote into the FIFO, modulo 128. Reads do not change it.
- R10: A byte written while the FIFO holds 128 unread bytes, with no read in that cycle, replaces the oldest byte, and `frm_ovfl` is set when that frame ends. A read in the same cycle as the write frees a slot, so nothing is overwritten.
- R11: A read strobe while the FIFO is empty changes nothing: the next byte written is the next byte read.
- R12: All five status bits and `frm_bytes` clear when the first data bit of the next frame leaves the flag-detection delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Line bit valid strobe |
| bit_in | input | 1 | Line bit |
| fcs_on | input | 1 | Enable FCS checking and FCS removal |
| rd_en | input | 1 | Read strobe, pops the oldest byte |
| rd_data | output | 8 | Oldest unread FIFO byte |
| fifo_empty | output | 1 | FIFO holds no unread byte |
| frm_done | output | 1 | Frame ended by flag or abort |
| frm_abort | output | 1 | Frame ended by abort |
| frm_nonoct | output | 1 | Frame length not a multiple of 8 bits |
| frm_ovfl | output | 1 | Frame overwrote unread FIFO data |
| frm_fcs_err | output | 1 | FCS mismatch |
| frm_bytes | output | 7 | Octets written by the frame, modulo 128 |

## Verification
A byte write and a processor read can fall in the same cycle while the FIFO is exactly full. The two must then net out to no overwrite. The bench fills the FIFO to 128 bytes with reads held off. It then strobes a read on exactly the line bit that completes the next octet, and expects `frm_ovfl`=0 and the old head to be gone with the new byte at the tail. A follow-up frame written with no reads must instead overwrite the oldest bytes and set `frm_ovfl`.

// File: rtl/hdlc_dl_rx.sv
module hdlc_dl_rx #(
  parameter int DEPTH = 128,
  parameter logic [15:0] RESIDUE = 16'hF0B8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          bit_in,
  input  logic          fcs_on,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic          fifo_empty,
  output logic          frm_done,
  output logic          frm_abort,
  output logic          frm_nonoct,
  output logic          frm_ovfl,
  output logic          frm_fcs_err,
  output logic [AW-1:0] frm_bytes
);

  logic [2:0]    ones, dcnt, bcnt;
  logic          in_frame, active, ovfl_acc;
  logic [6:0]    dly;
  logic [7:0]    sh, h0, h1;
  logic [1:0]    hcnt;
  logic [15:0]   crc;
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          push_v;
  logic [7:0]    push_d;

  wire is_flag  = bit_en && !bit_in && ones == 3'd6;
  wire is_abort = bit_en &&  bit_in && ones == 3'd6;
  wire is_stuff = bit_en && !bit_in && ones == 3'd5;
  wire dbit_v   = bit_en && in_frame && !is_flag && !is_abort && !is_stuff;
  wire pop_v    = dbit_v && dcnt == 3'd7;
  wire pb       = dly[0];

  wire [2:0]  bc     = active ? bcnt : 3'd0;
  wire [15:0] crc_b  = active ? crc : 16'hFFFF;
  wire [15:0] crc_n  = (crc_b >> 1) ^ ((crc_b[0] ^ pb) ? 16'h8408 : 16'h0000);
  wire [7:0]  byte_n = {pb, sh[7:1]};
  wire        byte_v = pop_v && bc == 3'd7;

  wire rd_ok = rd_en && cnt != '0;
  wire full  = cnt == (AW+1)'(DEPTH);
  wire ovw   = push_v && full && !rd_ok;

  always_comb begin
    push_v = 1'b0;
    push_d = byte_n;
    if (byte_v) begin
      if (!fcs_on) push_v = 1'b1;
      else if (hcnt == 2'd2) begin
        push_v = 1'b1;
        push_d = h0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones <= '0; dcnt <= '0; bcnt <= '0; dly <= '0; sh <= '0;
      in_frame <= 1'b0; active <= 1'b0; ovfl_acc <= 1'b0;
      h0 <= '0; h1 <= '0; hcnt <= '0; crc <= 16'hFFFF;
      frm_done <= 1'b0; frm_abort <= 1'b0; frm_nonoct <= 1'b0;
      frm_ovfl <= 1'b0; frm_fcs_err <= 1'b0; frm_bytes <= '0;
    end else begin
      if (bit_en) ones <= bit_in ? ((ones == 3'd7) ? 3'd7 : ones + 3'd1) : 3'd0;

      if (is_flag) begin
        in_frame <= 1'b1;
        dcnt <= '0;
        if (active) begin
          active <= 1'b0; hcnt <= '0;
          frm_done <= 1'b1; frm_abort <= 1'b0;
          frm_nonoct <= bcnt != 3'd0;
          frm_fcs_err <= fcs_on && crc != RESIDUE;
          frm_ovfl <= ovfl_acc;
        end
      end else if (is_abort) begin
        in_frame <= 1'b0;
        dcnt <= '0;
        if (active) begin
          active <= 1'b0; hcnt <= '0;
          frm_done <= 1'b1; frm_abort <= 1'b1;
          frm_nonoct <= 1'b0; frm_fcs_err <= 1'b0;
          frm_ovfl <= ovfl_acc;
        end
      end else if (dbit_v) begin
        dly <= {bit_in, dly[6:1]};
        if (dcnt != 3'd7) dcnt <= dcnt + 3'd1;
      end

      if (pop_v) begin
        bcnt <= bc + 3'd1;
        crc  <= crc_n;
        sh   <= byte_n;
        if (!active) begin
          active <= 1'b1; hcnt <= '0; ovfl_acc <= 1'b0;
          frm_done <= 1'b0; frm_abort <= 1'b0; frm_nonoct <= 1'b0;
          frm_ovfl <= 1'b0; frm_fcs_err <= 1'b0; frm_bytes <= '0;
        end
      end

      if (byte_v && fcs_on) begin
        if (hcnt == 2'd2) begin
          h0 <= h1;
          h1 <= byte_n;
        end else if (hcnt == 2'd1) begin
          h1 <= byte_n;
          hcnt <= 2'd2;
        end else begin
          h0 <= byte_n;
          hcnt <= 2'd1;
        end
      end

      if (push_v) frm_bytes <= frm_bytes + AW'(1);
      if (ovw) ovfl_acc <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_v) mem[wp] <= push_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push_v) wp <= wp + AW'(1);
      if (ovw || rd_ok) rp <= rp + AW'(1);
      cnt <= cnt + (AW+1)'(push_v && !ovw) - (AW+1)'(rd_ok);
    end
  end

  assign rd_data    = mem[rp];
  assign fifo_empty = cnt == '0;

endmodule

// File: rtl/hdlc_dl_rx_chk.sv
module hdlc_dl_rx_chk #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          push,
  input logic [AW:0]   fcnt,
  input logic          frm_done,
  input logic          frm_abort,
  input logic          frm_nonoct,
  input logic          frm_ovfl,
  input logic          frm_fcs_err,
  input logic [AW-1:0] frm_bytes
);

  assert_abort_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frm_abort |-> frm_done);

  assert_nonoct_flag_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frm_nonoct |-> (frm_done && !frm_abort));

  assert_fcs_flag_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frm_fcs_err |-> (frm_done && !frm_abort));

  assert_ovfl_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frm_ovfl |-> frm_done);

  assert_full_stays_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fcnt == (AW+1)'(DEPTH) && push && !rd_en) |=> fcnt == (AW+1)'(DEPTH));

  assert_empty_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fcnt == '0 && rd_en && !push) |=> fcnt == '0);

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (frm_bytes == $past(frm_bytes) || frm_bytes == '0 ||
              frm_bytes == $past(frm_bytes) + AW'(1)));

endmodule

bind hdlc_dl_rx hdlc_dl_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .push(push_v), .fcnt(cnt),
  .frm_done(frm_done), .frm_abort(frm_abort), .frm_nonoct(frm_nonoct),
  .frm_ovfl(frm_ovfl), .frm_fcs_err(frm_fcs_err), .frm_bytes(frm_bytes)
);

// File: tb/sim_hdlc_dl_rx.sv
`timescale 1ns/1ps
module sim_hdlc_dl_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_en = 1'b0, bit_in = 1'b0, fcs_on = 1'b0, rd_en = 1'b0;
  logic [7:0] rd_data;
  logic fifo_empty, frm_done, frm_abort, frm_nonoct, frm_ovfl, frm_fcs_err;
  logic [6:0] frm_bytes;

  int checks = 0, errors = 0, tx_ones = 0;
  bit drain = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] tx_q[$];

  always #4 clk = ~clk;

  hdlc_dl_rx u0 (.clk, .rst_n, .bit_en, .bit_in, .fcs_on, .rd_en, .rd_data,
    .fifo_empty, .frm_done, .frm_abort, .frm_nonoct, .frm_ovfl, .frm_fcs_err, .frm_bytes);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) r = (r >> 1) ^ ((r[0] ^ b[i]) ? 16'h8408 : 16'h0);
    return r;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk); bit_en = 1'b1; bit_in = b;
    @(negedge clk); bit_en = 1'b0;
  endtask

  task automatic send_dbit(input logic b);
    send_bit(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin send_bit(1'b0); tx_ones = 0; end
    end else tx_ones = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_dbit(b[i]);
  endtask

  task automatic send_flag();
    send_bit(1'b0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_bit(1'b0);
    tx_ones = 0;
  endtask

  task automatic expect_byte(input logic [7:0] b);
    exp_q.push_back(b);
    if (exp_q.size() > 128) void'(exp_q.pop_front());
  endtask

  task automatic send_frame(input bit bad);
    logic [15:0] c = 16'hFFFF;
    logic [15:0] f;
    send_flag();
    foreach (tx_q[i]) begin
      expect_byte(tx_q[i]);
      c = crc_upd(c, tx_q[i]);
      send_byte(tx_q[i]);
    end
    f = ~c;
    if (bad) f = f ^ 16'h0001;
    if (!fcs_on) begin expect_byte(f[7:0]); expect_byte(f[15:8]); end
    send_byte(f[7:0]);
    send_byte(f[15:8]);
    send_flag();
  endtask

  task automatic wait_drain();
    drain = 1'b1;
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
    @(negedge clk); @(negedge clk);
    chk("R4 drained", fifo_empty, 1'b1);
    chk("R4 queue empty", exp_q.size(), 0);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (drain) begin
        rd_en = 1'b0;
        if (!fifo_empty) begin
          if (exp_q.size() == 0) chk("R4 unexpected byte", rd_data, 8'hxx);
          else chk("R4 byte order", rd_data, exp_q.pop_front());
          rd_en = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 empty", fifo_empty, 1'b1);
    chk("R1 status", {frm_done, frm_abort, frm_nonoct, frm_ovfl, frm_fcs_err}, 5'b0);
    chk("R1 count", frm_bytes, 7'd0);

    send_flag(); send_flag(); send_flag();
    chk("R2 no frame empty", fifo_empty, 1'b1);
    chk("R2 no frame status", frm_done, 1'b0);

    drain = 1'b1;
    fcs_on = 1'b1;
    tx_q = '{8'h7E, 8'hFF, 8'h3F, 8'h01, 8'hF8};
    send_frame(1'b0);
    chk("R4 done", frm_done, 1'b1);
    chk("R4 abort clear", frm_abort, 1'b0);
    chk("R7 fcs good", frm_fcs_err, 1'b0);
    chk("R3 octet aligned", frm_nonoct, 1'b0);
    chk("R9 count excl fcs", frm_bytes, 7'd5);
    wait_drain();

    tx_q = '{8'hA5, 8'h1F};
    send_frame(1'b1);
    chk("R7 fcs bad", frm_fcs_err, 1'b1);
    chk("R7 count", frm_bytes, 7'd2);
    wait_drain();

    fcs_on = 1'b0;
    tx_q = '{8'h10, 8'h20, 8'hFE};
    send_frame(1'b1);
    chk("R8 fcs ignored", frm_fcs_err, 1'b0);
    chk("R8 count incl fcs", frm_bytes, 7'd5);
    wait_drain();

    send_flag();
    expect_byte(8'h00); send_byte(8'h00);
    send_dbit(1'b1); send_dbit(1'b0); send_dbit(1'b1);
    send_flag();
    chk("R6 nonoct", frm_nonoct, 1'b1);
    chk("R6 count", frm_bytes, 7'd1);
    wait_drain();

    send_flag();
    expect_byte(8'h12); send_byte(8'h12);
    expect_byte(8'h34); send_byte(8'h34);
    chk("R12 done cleared", frm_done, 1'b0);
    chk("R12 nonoct cleared", frm_nonoct, 1'b0);
    chk("R12 count restart", frm_bytes, 7'd1);
    send_flag();
    chk("R12 closed", {frm_done, frm_nonoct}, 2'b10);
    chk("R12 count", frm_bytes, 7'd2);
    wait_drain();

    fcs_on = 1'b1;
    send_flag();
    expect_byte(8'h11);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    send_bit(1'b0);
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    tx_ones = 0;
    chk("R5 abort", {frm_done, frm_abort, frm_nonoct, frm_fcs_err}, 4'b1100);
    chk("R5 count", frm_bytes, 7'd1);
    send_byte(8'h00);
    chk("R5 ignored after abort", frm_bytes, 7'd1);
    send_flag();
    wait_drain();

    drain = 1'b0; rd_en = 1'b0;
    fcs_on = 1'b0;
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk("R11 still empty", fifo_empty, 1'b1);
    tx_q = '{8'hC3};
    send_frame(1'b0);
    chk("R11 head after empty read", rd_data, 8'hC3);
    wait_drain();

    drain = 1'b0; rd_en = 1'b0;
    tx_q.delete();
    for (int i = 0; i < 126; i++) tx_q.push_back(8'(i * 5 + 1));
    send_frame(1'b0);
    chk("R9 count wraps", frm_bytes, 7'd0);
    chk("R10 no ovfl at full", frm_ovfl, 1'b0);
    send_flag();
    send_byte(8'h00);
    send_bit(1'b0);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    chk("R10 head before", rd_data, exp_q[0]);
    @(negedge clk); bit_en = 1'b1; bit_in = 1'b1; rd_en = 1'b1;
    @(negedge clk); bit_en = 1'b0; rd_en = 1'b0;
    void'(exp_q.pop_front());
    exp_q.push_back(8'h00);
    send_bit(1'b0);
    tx_ones = 0;
    chk("R10 same-cycle no ovfl", frm_ovfl, 1'b0);
    chk("R10 same-cycle count", frm_bytes, 7'd1);
    chk("R10 head after", rd_data, exp_q[0]);

    tx_q = '{8'h5A};
    send_frame(1'b0);
    chk("R10 overflow", frm_ovfl, 1'b1);
    chk("R10 count", frm_bytes, 7'd3);
    chk("R10 oldest lost", rd_data, exp_q[0]);
    wait_drain();
    chk("R9 reads keep count", frm_bytes, 7'd3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule